// File: doc/BRIEF.md
# Display-Aware Memory Map Decoder

This block sits between a CPU's 16-bit address, 8-bit data bus and the memories behind it. On every access it works out which target is being addressed: cartridge ROM, a small boot ROM that overlays the bottom of the map, video RAM, external cartridge RAM, a fixed work-RAM bank, a switchable work-RAM bank, sprite attribute memory or the I/O page. It raises one chip select for that target and gives the local offset inside it. The decode is combinational, so a target sees its select and offset in the same cycle as the CPU's strobe.

Access to video RAM and sprite memory depends on the display controller's current mode. A blocked or unmapped access raises no chip select. A read that raises no select returns all ones. Read data is registered: the decoder remembers which target a read selected and returns that target's read data one cycle later, when the targets' synchronous outputs are valid. A write needs no data path through the block, because each target takes the CPU write data directly and only needs its select together with the write strobe.

Top module: `mmap_decoder`

## Requirements
- R1: After reset, no chip select is active and `rd_valid` is 0. The boot overlay is enabled.
- R2: Any access to 0x0000–0x7FFF that the overlay does not claim selects cartridge ROM (`tgt_sel` bit 0). The offset is address bits [14:0]. Writes in this range also select the cartridge, which takes them as control writes.
- R3: While the overlay is enabled, a read below 0x0100 selects the boot ROM (bit 1) with offset address[7:0]. Writes below 0x0100 still go to cartridge ROM.
- R4: Once `boot_off` has been sampled high on a clock edge, the overlay stays disabled until the next reset, and reads below 0x0100 go to cartridge ROM.
- R5: 0x8000–0x9FFF selects video RAM (bit 2) with offset [12:0]. 0xA000–0xBFFF selects external RAM (bit 3) with offset [12:0]. 0xC000–0xCFFF selects work bank 0 (bit 4) and 0xD000–0xDFFF selects the switchable bank (bit 5), both with offset [11:0].
- R6: 0xE000–0xFDFF mirrors work RAM. When address bit 12 is 0 it selects bank 0, and when bit 12 is 1 it selects the switchable bank. The offset is [11:0].
- R7: `disp_mode` is encoded as 0 for horizontal blank, 1 for vertical blank, 2 for sprite scan and 3 for pixel transfer. Sprite memory at 0xFE00–0xFE9F (bit 6, offset [7:0]) is selected only in modes 0 and 1. In other modes, reads return 0xFF and writes are dropped.
- R8: In mode 3, an access to video RAM raises no select. A read there returns 0xFF.
- R9: An access to 0xFEA0–0xFEFF raises no select. A read there returns 0xFF.
- R10: 0xFF00–0xFFFF selects the I/O page (bit 7) with offset [7:0].
- R11: `rd_valid` is high in the cycle after each cycle with `cpu_rd` high. `rd_data` then carries that cycle's read data input of the target the read selected, or 0xFF if the read selected none.
- R12: At most one `tgt_sel` bit is high, and none is high while neither `cpu_rd` nor `cpu_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| disp_mode | input | 2 | Display controller mode (0 h-blank, 1 v-blank, 2 scan, 3 pixel transfer) |
| boot_off | input | 1 | Disables the boot overlay until reset |
| rom_rdata | input | 8 | Cartridge ROM read data |
| boot_rdata | input | 8 | Boot ROM read data |
| vram_rdata | input | 8 | Video RAM read data |
| xram_rdata | input | 8 | External RAM read data |
| wram0_rdata | input | 8 | Work bank 0 read data |
| wramx_rdata | input | 8 | Switchable work bank read data |
| spr_rdata | input | 8 | Sprite memory read data |
| io_rdata | input | 8 | I/O page read data |
| tgt_sel | output | 8 | One-hot chip selects (bit order as in R2–R10) |
| tgt_ofs | output | 15 | Offset within the selected target |
| rd_valid | output | 1 | Read data phase |
| rd_data | output | 8 | Registered-select read data |

## Verification
The assertions assume that `cpu_rd` and `cpu_wr` are never high in the same cycle. They also assume that `disp_mode` and the address are held steady from one falling clock edge to the next. The bench keeps to this by changing every input only on the falling edge and by issuing each access as either a read or a write. The read data inputs are held at a distinct constant for each target. This lets the bench tell from `rd_data` which target a read reached, while the offset is checked at the ports in the cycle of the access.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
   localparam int TGT_W   = 4;
   localparam int NUM_TGT = 8;

   typedef enum logic [TGT_W-1:0] {
      T_NONE  = 4'd0,
      T_ROM   = 4'd1,
      T_BOOT  = 4'd2,
      T_VRAM  = 4'd3,
      T_XRAM  = 4'd4,
      T_WRAM0 = 4'd5,
      T_WRAMX = 4'd6,
      T_SPR   = 4'd7,
      T_IO    = 4'd8
   } tgt_e;

   typedef enum logic [1:0] {
      MD_HBLANK = 2'd0,
      MD_VBLANK = 2'd1,
      MD_SCAN   = 2'd2,
      MD_PIXEL  = 2'd3
   } disp_mode_e;
endpackage

// File: rtl/mmap_boot_ctl.sv
module mmap_boot_ctl #(
   parameter bit BOOT_AT_RESET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic boot_off,
   output logic boot_on
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        boot_on <= BOOT_AT_RESET;
      else if (boot_off) boot_on <= 1'b0;
   end

   // R4: once cleared the overlay never comes back before reset
   assert_boot_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_on |=> !boot_on);
   assert_boot_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      boot_off |=> !boot_on);
endmodule

// File: rtl/mmap_region_decode.sv
module mmap_region_decode
   import mmap_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int BOOT_BYTES   = 256,
   parameter bit SPR_WR_GATED = 1'b1,
   localparam int OFS_W       = ADDR_W - 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_wr,
   input  logic [1:0]        mode,
   input  logic              boot_on,
   output tgt_e              tgt,
   output logic [OFS_W-1:0]  ofs
);
   localparam logic [ADDR_W-1:0] BOOT_END = ADDR_W'(BOOT_BYTES);
   localparam logic [ADDR_W-1:0] XRAM_LO  = ADDR_W'(16'hA000);
   localparam logic [ADDR_W-1:0] WRAM0_LO = ADDR_W'(16'hC000);
   localparam logic [ADDR_W-1:0] WRAMX_LO = ADDR_W'(16'hD000);
   localparam logic [ADDR_W-1:0] ECHO_LO  = ADDR_W'(16'hE000);
   localparam logic [ADDR_W-1:0] SPR_LO   = ADDR_W'(16'hFE00);
   localparam logic [ADDR_W-1:0] HOLE_LO  = ADDR_W'(16'hFEA0);
   localparam logic [ADDR_W-1:0] IO_LO    = ADDR_W'(16'hFF00);

   logic in_blank, spr_ok, vram_ok;

   assign in_blank = (mode == MD_HBLANK) || (mode == MD_VBLANK);
   assign vram_ok  = (mode != MD_PIXEL);

   generate
      if (SPR_WR_GATED) begin : g_spr_wr_gated
         assign spr_ok = in_blank;
      end else begin : g_spr_wr_open
         assign spr_ok = in_blank || is_wr;
      end
   endgenerate

   always_comb begin
      tgt = T_NONE;
      ofs = '0;
      if (!addr[ADDR_W-1]) begin
         if (!is_wr && boot_on && (addr < BOOT_END)) begin
            tgt = T_BOOT;
            ofs = OFS_W'(addr & (BOOT_END - 1'b1));
         end else begin
            tgt = T_ROM;
            ofs = addr[OFS_W-1:0];
         end
      end else if (addr < XRAM_LO) begin
         if (vram_ok) begin
            tgt = T_VRAM;
            ofs = OFS_W'(addr[12:0]);
         end
      end else if (addr < WRAM0_LO) begin
         tgt = T_XRAM;
         ofs = OFS_W'(addr[12:0]);
      end else if (addr < WRAMX_LO) begin
         tgt = T_WRAM0;
         ofs = OFS_W'(addr[11:0]);
      end else if (addr < ECHO_LO) begin
         tgt = T_WRAMX;
         ofs = OFS_W'(addr[11:0]);
      end else if (addr < SPR_LO) begin
         tgt = addr[12] ? T_WRAMX : T_WRAM0;
         ofs = OFS_W'(addr[11:0]);
      end else if (addr < HOLE_LO) begin
         if (spr_ok) begin
            tgt = T_SPR;
            ofs = OFS_W'(addr[7:0]);
         end
      end else if (addr >= IO_LO) begin
         tgt = T_IO;
         ofs = OFS_W'(addr[7:0]);
      end
   end
endmodule

// File: rtl/mmap_read_mux.sv
module mmap_read_mux
   import mmap_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(NUM_TGT)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cap,
   input  tgt_e                           tgt,
   input  logic [NUM_TGT-1:0][DATA_W-1:0] rd_bus,
   output logic                           rd_valid,
   output logic [DATA_W-1:0]              rd_data
);
   tgt_e             rd_q;
   logic [IDX_W-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q     <= T_NONE;
         rd_valid <= 1'b0;
      end else begin
         rd_q     <= cap ? tgt : T_NONE;
         rd_valid <= cap;
      end
   end

   assign idx     = IDX_W'(rd_q - 4'd1);
   assign rd_data = (rd_valid && rd_q != T_NONE) ? rd_bus[idx] : '1;

   // R11: data phase follows every read strobe by exactly one cycle
   assert_rd_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> rd_valid);
   assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> !rd_valid);
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
   import mmap_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter int BOOT_BYTES    = 256,
   parameter bit BOOT_AT_RESET = 1'b1,
   parameter bit SPR_WR_GATED  = 1'b1,
   localparam int OFS_W        = ADDR_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [1:0]        disp_mode,
   input  logic              boot_off,
   input  logic [DATA_W-1:0] rom_rdata,
   input  logic [DATA_W-1:0] boot_rdata,
   input  logic [DATA_W-1:0] vram_rdata,
   input  logic [DATA_W-1:0] xram_rdata,
   input  logic [DATA_W-1:0] wram0_rdata,
   input  logic [DATA_W-1:0] wramx_rdata,
   input  logic [DATA_W-1:0] spr_rdata,
   input  logic [DATA_W-1:0] io_rdata,
   output logic [7:0]        tgt_sel,
   output logic [OFS_W-1:0]  tgt_ofs,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   if (ADDR_W != 16) begin : g_bad_addr_w
      $error("mmap_decoder: ADDR_W must be 16");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("mmap_decoder: DATA_W must be positive");
   end
   if (BOOT_BYTES < 2 || BOOT_BYTES > 16384 || (BOOT_BYTES & (BOOT_BYTES - 1)) != 0) begin : g_bad_boot
      $error("mmap_decoder: BOOT_BYTES must be a power of two up to 16384");
   end

   logic boot_on, access, is_wr;
   tgt_e tgt;
   logic [NUM_TGT-1:0][DATA_W-1:0] rd_bus;

   assign access = cpu_rd || cpu_wr;
   assign is_wr  = cpu_wr && !cpu_rd;

   mmap_boot_ctl #(.BOOT_AT_RESET(BOOT_AT_RESET)) u_boot (
      .clk(clk), .rst_n(rst_n), .boot_off(boot_off), .boot_on(boot_on));

   mmap_region_decode #(
      .ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES), .SPR_WR_GATED(SPR_WR_GATED)
   ) u_dec (
      .addr(cpu_addr), .is_wr(is_wr), .mode(disp_mode), .boot_on(boot_on),
      .tgt(tgt), .ofs(tgt_ofs));

   generate
      for (genvar i = 0; i < NUM_TGT; i++) begin : g_sel
         assign tgt_sel[i] = access && (tgt == tgt_e'(i + 1));
      end
   endgenerate

   assign rd_bus = {io_rdata, spr_rdata, wramx_rdata, wram0_rdata,
                    xram_rdata, vram_rdata, boot_rdata, rom_rdata};

   mmap_read_mux #(.DATA_W(DATA_W)) u_rmux (
      .clk(clk), .rst_n(rst_n), .cap(cpu_rd), .tgt(tgt), .rd_bus(rd_bus),
      .rd_valid(rd_valid), .rd_data(rd_data));

   // R12: single target, and only during an access
   assert_sel_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tgt_sel));
   assert_sel_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !access |-> (tgt_sel == '0));
   // R7: sprite memory reachable only in the blanking modes
   assert_spr_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_sel[6] |-> (disp_mode == MD_HBLANK || disp_mode == MD_VBLANK));
   // R8: video RAM closed during pixel transfer
   assert_vram_pixel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_sel[2] |-> (disp_mode != MD_PIXEL));
   // R9: a read that selected nothing returns all ones
   assert_open_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && tgt_sel == '0) |=> (rd_data == '1));
endmodule

// File: tb/mmap_decoder_test.sv
module mmap_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic        rd = 1'b0, wr = 1'b0, boot_off = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [7:0]  tgt_sel, rd_data;
   logic [14:0] tgt_ofs;
   logic        rd_valid;
   int          n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   mmap_decoder uut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(addr), .cpu_rd(rd), .cpu_wr(wr),
      .disp_mode(mode), .boot_off(boot_off),
      .rom_rdata(8'h11), .boot_rdata(8'h22), .vram_rdata(8'h33), .xram_rdata(8'h44),
      .wram0_rdata(8'h55), .wramx_rdata(8'h66), .spr_rdata(8'h77), .io_rdata(8'h88),
      .tgt_sel(tgt_sel), .tgt_ofs(tgt_ofs), .rd_valid(rd_valid), .rd_data(rd_data));

   function automatic logic [7:0] data_for(input logic [7:0] sel);
      case (sel)
         8'h01: return 8'h11;  8'h02: return 8'h22;
         8'h04: return 8'h33;  8'h08: return 8'h44;
         8'h10: return 8'h55;  8'h20: return 8'h66;
         8'h40: return 8'h77;  8'h80: return 8'h88;
         default: return 8'hFF;
      endcase
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one access; checks select and offset now, read data one cycle later
   task automatic acc(input logic [15:0] a, input logic r, input logic [1:0] m,
                      input logic [7:0] esel, input logic [14:0] eofs, input string tag);
      @(negedge clk);
      addr = a; rd = r; wr = !r; mode = m;
      #1;
      chk(tgt_sel == esel, {tag, " sel"}, 16'(tgt_sel), 16'(esel));
      if (esel != 0) chk(tgt_ofs == eofs, {tag, " ofs"}, 16'(tgt_ofs), 16'(eofs));
      if (r) begin
         @(negedge clk);
         rd = 1'b0;
         #1;
         chk(rd_valid == 1'b1, {tag, " valid"}, 16'(rd_valid), 16'd1);
         chk(rd_data == data_for(esel), {tag, " data"}, 16'(rd_data), 16'(data_for(esel)));
      end else begin
         wr = 1'b0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; rd = 0; wr = 0; boot_off = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();  // R1
      do_reset();
      #1;
      chk(tgt_sel == 8'h00, "R1 idle sel", 16'(tgt_sel), 16'h0);
      chk(rd_valid == 1'b0, "R1 valid", 16'(rd_valid), 16'h0);
      acc(16'h0050, 1, 0, 8'h02, 15'h0050, "R1 overlay on");
   endtask

   task automatic t_rom();  // R2
      acc(16'h1234, 1, 0, 8'h01, 15'h1234, "R2 read");
      acc(16'h7FFF, 1, 3, 8'h01, 15'h7FFF, "R2 top");
      acc(16'h2000, 0, 2, 8'h01, 15'h2000, "R2 write");
   endtask

   task automatic t_boot();  // R3
      acc(16'h00FF, 1, 1, 8'h02, 15'h00FF, "R3 last");
      acc(16'h0100, 1, 1, 8'h01, 15'h0100, "R3 above");
      acc(16'h0010, 0, 1, 8'h01, 15'h0010, "R3 write");
   endtask

   task automatic t_banks();  // R5
      acc(16'h8000, 1, 0, 8'h04, 15'h0000, "R5 vram lo");
      acc(16'h9FFF, 1, 2, 8'h04, 15'h1FFF, "R5 vram hi");
      acc(16'hA123, 1, 3, 8'h08, 15'h0123, "R5 xram");
      acc(16'hC000, 1, 0, 8'h10, 15'h0000, "R5 wram0");
      acc(16'hCFFF, 0, 0, 8'h10, 15'h0FFF, "R5 wram0 wr");
      acc(16'hD800, 1, 2, 8'h20, 15'h0800, "R5 wramx");
   endtask

   task automatic t_echo();  // R6
      acc(16'hE010, 1, 0, 8'h10, 15'h0010, "R6 bank0");
      acc(16'hEFFF, 1, 3, 8'h10, 15'h0FFF, "R6 bank0 top");
      acc(16'hF000, 1, 0, 8'h20, 15'h0000, "R6 bankx");
      acc(16'hFDFF, 1, 1, 8'h20, 15'h0DFF, "R6 end");
      acc(16'hF123, 0, 2, 8'h20, 15'h0123, "R6 write");
   endtask

   task automatic t_sprite();  // R7
      acc(16'hFE00, 1, 0, 8'h40, 15'h0000, "R7 hblank");
      acc(16'hFE9F, 1, 1, 8'h40, 15'h009F, "R7 vblank");
      acc(16'hFE40, 1, 2, 8'h00, 15'h0000, "R7 scan read");
      acc(16'hFE40, 1, 3, 8'h00, 15'h0000, "R7 pixel read");
      acc(16'hFE10, 0, 3, 8'h00, 15'h0000, "R7 pixel write");
      acc(16'hFE10, 0, 1, 8'h40, 15'h0010, "R7 blank write");
   endtask

   task automatic t_vram_block();  // R8
      acc(16'h8100, 1, 3, 8'h00, 15'h0000, "R8 read");
      acc(16'h9000, 0, 3, 8'h00, 15'h0000, "R8 write");
   endtask

   task automatic t_hole_io();  // R9, R10
      acc(16'hFEA0, 1, 0, 8'h00, 15'h0000, "R9 read");
      acc(16'hFEFF, 0, 1, 8'h00, 15'h0000, "R9 write");
      acc(16'hFF00, 1, 2, 8'h80, 15'h0000, "R10 lo");
      acc(16'hFFFF, 1, 3, 8'h80, 15'h00FF, "R10 hi");
   endtask

   task automatic t_idle();  // R12
      @(negedge clk);
      addr = 16'hC000; rd = 0; wr = 0;
      #1;
      chk(tgt_sel == 8'h00, "R12 no strobe", 16'(tgt_sel), 16'h0);
   endtask

   task automatic t_back_to_back();  // R11
      @(negedge clk);
      addr = 16'hA000; rd = 1; mode = 0;
      @(negedge clk);
      #1;
      chk(rd_data == 8'h44, "R11 first", 16'(rd_data), 16'h44);
      addr = 16'hFF10;
      @(negedge clk);
      rd = 0;
      #1;
      chk(rd_data == 8'h88, "R11 second", 16'(rd_data), 16'h88);
      @(negedge clk);
      #1;
      chk(rd_valid == 1'b0, "R11 idle", 16'(rd_valid), 16'h0);
   endtask

   task automatic t_boot_off();  // R4
      @(negedge clk);
      boot_off = 1'b1;
      @(negedge clk);
      boot_off = 1'b0;
      acc(16'h0000, 1, 0, 8'h01, 15'h0000, "R4 off");
      repeat (3) @(negedge clk);
      acc(16'h00C0, 1, 1, 8'h01, 15'h00C0, "R4 stays off");
      do_reset();
      acc(16'h0000, 1, 0, 8'h02, 15'h0000, "R4 back after reset");
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_rom();
      t_boot();
      t_banks();
      t_echo();
      t_sprite();
      t_vram_block();
      t_hole_io();
      t_idle();
      t_back_to_back();
      t_boot_off();
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule